// File: doc/BRIEF.md
# External bus width adapter

This block connects an internal bus master that issues byte, word (16-bit) and longword (32-bit) requests to an external memory bus that is 16 bits wide. Each address area of the external space is set up as either a narrow area, where a peripheral only has 8 data lines, or a wide area, where all 16 lines are used. A master request is turned into one or more external bus cycles. The block drives each cycle's address, its byte-lane enables and its write data on the right lanes, and then waits for the external side to signal ready.

On reads the bytes returned by each external cycle are joined into one right-justified result, most significant byte first. The master sees a single completion pulse after the last cycle. Requests that break the alignment rules, or that use the reserved size code, are rejected with an error pulse and never reach the external bus. Per-area widths come from a configuration vector, and the width is captured when a request is accepted.

Top module: `ext_bus_sizer`

## Requirements
- R1: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high; `req_ready` is high exactly when no request is in progress, and `req_valid` while busy has no effect.
- R2: The area index is the top `AREA_W` address bits (addr[23:21] by default); bit i of `area_wide` set to 1 marks area i as 16-bit, 0 as 8-bit. The bit is sampled at acceptance, and later changes do not affect a request that is already running.
- R3: In an 8-bit area every external cycle moves one byte on the upper lane `ext_wdata[15:8]` / `ext_rdata[15:8]` with only `ext_upper_en` set; a word takes two cycles and a longword four, and the address rises by 1 per cycle.
- R4: In a 16-bit area a byte request is one cycle: an even address uses the upper lane (`ext_upper_en`), an odd address uses the lower lane bits [7:0] (`ext_lower_en`).
- R5: In a 16-bit area a word request is one cycle with both enables set, and a longword is two such cycles with the address rising by 2.
- R6: Data is big-endian: the most significant byte goes in the first cycle at the lowest address, and in a word cycle the lower-addressed byte sits on the upper lane.
- R7: Size codes are 0 byte, 1 word, 2 longword, 3 reserved. A word or longword at an odd address, or size code 3, gives a one-cycle `err` pulse on the edge after acceptance, with no external cycle and no `done`.
- R8: `ext_valid` stays high, and address, enables, direction and write data stay stable, until `ext_ready` is sampled high; then the block moves to the next cycle or ends.
- R9: For reads, `rdata` holds the assembled result, right-justified (byte in [7:0], word in [15:0]), when `done` pulses for one cycle on the edge after the final handshake. It keeps that value until the next request is accepted.
- R10: For writes, the lane that carries no data is driven to zero, and `done` pulses one cycle after the final handshake just as for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Master request strobe |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data, right-justified |
| area_wide | input | 2**AREA_W | Per-area width, 1 = 16-bit |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rdata | output | 32 | Assembled read result |
| ext_valid | output | 1 | External cycle in progress |
| ext_write | output | 1 | External cycle direction |
| ext_addr | output | ADDR_W | External byte address |
| ext_upper_en | output | 1 | Upper lane [15:8] enable |
| ext_lower_en | output | 1 | Lower lane [7:0] enable |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_ready | input | 1 | External cycle completes |

## Verification
The bench targets odd and even byte addresses in wide areas, where a design that chose the wrong lane would read the garbage byte the responder puts on the unused lane. It runs longword splits in both area widths, which show a wrong address step or a little-endian byte order as a mismatch at a specific cycle. Misaligned and reserved-size requests are checked to produce no external cycle at all. A width bit flipped during a running transfer, and a stray request while busy, would show up as extra or reshaped cycles. Random ready stalls expose any design that advances before the handshake.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   localparam int BYTE_W     = 8;
   localparam int LANE_W     = 16;
   localparam int MDATA_W    = 32;
   localparam int MDATA_BYTES = MDATA_W / BYTE_W;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   function automatic logic [2:0] size_bytes(input xfer_size_e sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_WORD: size_bytes = 3'd2;
         SZ_LONG: size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/ebs_planner.sv
module ebs_planner
   import ebs_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int AREA_W = 3
) (
   input  logic [1:0]          size_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [(1<<AREA_W)-1:0] area_wide_i,
   output logic                plan_ok_o,
   output logic                wide_o,
   output logic                word_mode_o,
   output logic [2:0]          n_cyc_o,
   output logic [4:0]          lead_shift_o
);
   localparam int N_AREAS  = 1 << AREA_W;
   localparam int AREA_LSB = ADDR_W - AREA_W;

   logic [AREA_W-1:0]  area_idx;
   logic [N_AREAS-1:0] area_hit;
   logic [2:0]         nbytes;
   xfer_size_e         sz;

   assign sz       = xfer_size_e'(size_i);
   assign area_idx = addr_i[ADDR_W-1 -: AREA_W];

   generate
      for (genvar g = 0; g < N_AREAS; g++) begin : g_area
         assign area_hit[g] = (area_idx == AREA_W'(g)) && area_wide_i[g];
      end
   endgenerate

   assign wide_o = |area_hit;
   assign nbytes = size_bytes(sz);

   always_comb begin
      plan_ok_o = 1'b1;
      if (sz == SZ_RSVD) plan_ok_o = 1'b0;
      if ((sz == SZ_WORD || sz == SZ_LONG) && addr_i[0]) plan_ok_o = 1'b0;
   end

   assign word_mode_o = wide_o && (sz != SZ_BYTE);

   always_comb begin
      if (word_mode_o) n_cyc_o = {1'b0, nbytes[2:1]};
      else             n_cyc_o = nbytes;
   end

   // shift that moves the payload's most significant byte to bit 31
   always_comb begin
      case (sz)
         SZ_BYTE: lead_shift_o = 5'd24;
         SZ_WORD: lead_shift_o = 5'd16;
         default: lead_shift_o = 5'd0;
      endcase
   end

   generate
      if (AREA_LSB < 1) begin : g_bad_area
         initial $error("ebs_planner: AREA_W must leave at least one low address bit");
      end
   endgenerate

endmodule

// File: rtl/ebs_lanes.sv
module ebs_lanes
   import ebs_pkg::*;
(
   input  logic              active_i,
   input  logic              wide_i,
   input  logic              word_mode_i,
   input  logic              addr0_i,
   input  logic [LANE_W-1:0] head_i,
   input  logic [LANE_W-1:0] ext_rdata_i,
   output logic              upper_en_o,
   output logic              lower_en_o,
   output logic [LANE_W-1:0] wdata_o,
   output logic [LANE_W-1:0] rd_chunk_o
);
   logic use_upper;
   logic use_lower;

   always_comb begin
      if (word_mode_i) begin
         use_upper = 1'b1;
         use_lower = 1'b1;
      end else if (!wide_i) begin
         use_upper = 1'b1;
         use_lower = 1'b0;
      end else begin
         use_upper = !addr0_i;
         use_lower = addr0_i;
      end
   end

   assign upper_en_o = active_i && use_upper;
   assign lower_en_o = active_i && use_lower;

   always_comb begin
      if (word_mode_i)    wdata_o = head_i;
      else if (use_lower) wdata_o = {{BYTE_W{1'b0}}, head_i[LANE_W-1 -: BYTE_W]};
      else                wdata_o = {head_i[LANE_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
   end

   always_comb begin
      if (word_mode_i)    rd_chunk_o = ext_rdata_i;
      else if (use_lower) rd_chunk_o = {{BYTE_W{1'b0}}, ext_rdata_i[BYTE_W-1:0]};
      else                rd_chunk_o = {{BYTE_W{1'b0}}, ext_rdata_i[LANE_W-1 -: BYTE_W]};
   end

endmodule

// File: rtl/ebs_gather.sv
module ebs_gather
   import ebs_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               load_i,
   input  logic               word_mode_i,
   input  logic [LANE_W-1:0]  chunk_i,
   output logic [MDATA_W-1:0] acc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
      end else if (clear_i) begin
         acc_o <= '0;
      end else if (load_i) begin
         if (word_mode_i) acc_o <= {acc_o[MDATA_W-LANE_W-1:0], chunk_i};
         else             acc_o <= {acc_o[MDATA_W-BYTE_W-1:0], chunk_i[BYTE_W-1:0]};
      end
   end

endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer
   import ebs_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int AREA_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [1:0]               req_size,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [31:0]              req_wdata,
   input  logic [(1<<AREA_W)-1:0]   area_wide,
   output logic                     done,
   output logic                     err,
   output logic [31:0]              rdata,
   output logic                     ext_valid,
   output logic                     ext_write,
   output logic [ADDR_W-1:0]        ext_addr,
   output logic                     ext_upper_en,
   output logic                     ext_lower_en,
   output logic [15:0]              ext_wdata,
   input  logic [15:0]              ext_rdata,
   input  logic                     ext_ready
);
   localparam int N_AREAS = 1 << AREA_W;

   seq_state_e          state_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                wide_q;
   logic                word_mode_q;
   logic                write_q;
   logic [2:0]          left_q;
   logic [MDATA_W-1:0]  wsh_q;
   logic                done_q;
   logic                err_q;

   logic                plan_ok;
   logic                plan_wide;
   logic                plan_word;
   logic [2:0]          plan_ncyc;
   logic [4:0]          plan_shift;
   logic                accept;
   logic                hs;
   logic                last;
   logic [LANE_W-1:0]   rd_chunk;

   ebs_planner #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_plan (
      .size_i       (req_size),
      .addr_i       (req_addr),
      .area_wide_i  (area_wide),
      .plan_ok_o    (plan_ok),
      .wide_o       (plan_wide),
      .word_mode_o  (plan_word),
      .n_cyc_o      (plan_ncyc),
      .lead_shift_o (plan_shift)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign ext_valid = (state_q == ST_RUN);
   assign hs        = ext_valid && ext_ready;
   assign last      = (left_q == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         wide_q      <= 1'b0;
         word_mode_q <= 1'b0;
         write_q     <= 1'b0;
         left_q      <= '0;
         wsh_q       <= '0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (!plan_ok) begin
               err_q <= 1'b1;
            end else begin
               state_q     <= ST_RUN;
               addr_q      <= req_addr;
               wide_q      <= plan_wide;
               word_mode_q <= plan_word;
               write_q     <= req_write;
               left_q      <= plan_ncyc - 3'd1;
               wsh_q       <= req_wdata << plan_shift;
            end
         end else if (hs) begin
            if (last) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               left_q <= left_q - 3'd1;
               if (word_mode_q) begin
                  addr_q <= addr_q + ADDR_W'(2);
                  wsh_q  <= wsh_q << LANE_W;
               end else begin
                  addr_q <= addr_q + ADDR_W'(1);
                  wsh_q  <= wsh_q << BYTE_W;
               end
            end
         end
      end
   end

   ebs_lanes u_lanes (
      .active_i    (ext_valid),
      .wide_i      (wide_q),
      .word_mode_i (word_mode_q),
      .addr0_i     (addr_q[0]),
      .head_i      (wsh_q[MDATA_W-1 -: LANE_W]),
      .ext_rdata_i (ext_rdata),
      .upper_en_o  (ext_upper_en),
      .lower_en_o  (ext_lower_en),
      .wdata_o     (ext_wdata),
      .rd_chunk_o  (rd_chunk)
   );

   ebs_gather u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (accept && plan_ok),
      .load_i      (hs && !write_q),
      .word_mode_i (word_mode_q),
      .chunk_i     (rd_chunk),
      .acc_o       (rdata)
   );

   assign ext_write = write_q;
   assign ext_addr  = addr_q;
   assign done      = done_q;
   assign err       = err_q;

   generate
      if (ADDR_W <= AREA_W) begin : g_bad_addr
         initial $error("ext_bus_sizer: ADDR_W must exceed AREA_W");
      end
      if (N_AREAS > 256) begin : g_bad_areas
         initial $error("ext_bus_sizer: AREA_W too large");
      end
   endgenerate

   // R8
   hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr) && $stable(ext_wdata)
                                  && $stable(ext_upper_en) && $stable(ext_lower_en));

   // R3
   narrow_upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid && !wide_q |-> ext_upper_en && !ext_lower_en);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid && ext_ready && left_q != 3'd0 |=>
         ext_addr == $past(ext_addr) + ($past(word_mode_q) ? ADDR_W'(2) : ADDR_W'(1)));

   // R7
   err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !ext_valid && !done);

   // R9
   done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(ext_valid && ext_ready) && !ext_valid);

   // R4
   lane_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_valid |-> ext_upper_en || ext_lower_en);

endmodule

// File: tb/ext_bus_sizer_tb.sv
`timescale 1ns/1ps
module ext_bus_sizer_tb;
   localparam int ADDR_W = 24;
   localparam int AREA_W = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [23:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [7:0]  area_wide = 8'b1010_1010;
   logic        done, err;
   logic [31:0] rdata;
   logic        ext_valid, ext_write, ext_upper_en, ext_lower_en;
   logic [23:0] ext_addr;
   logic [15:0] ext_wdata;
   logic [15:0] ext_rdata = '0;
   logic        ext_ready = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // cycle item: {write, addr[23:0], upper, lower, wdata[15:0]}
   logic [42:0] exp_cyc[$];
   // result item: {is_err, is_read, data[31:0]}
   logic [33:0] exp_res[$];

   always #4 clk = ~clk;

   ext_bus_sizer #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .area_wide(area_wide), .done(done), .err(err),
      .rdata(rdata), .ext_valid(ext_valid), .ext_write(ext_write),
      .ext_addr(ext_addr), .ext_upper_en(ext_upper_en), .ext_lower_en(ext_lower_en),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready)
   );

   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: builds the expected cycles from the requirements, then issues the request
   task automatic issue(input bit wr, input logic [1:0] sz, input logic [23:0] a, input logic [31:0] wd);
      int nb;
      bit wide;
      logic [7:0] b[4];
      logic [31:0] rd_exp;
      wide = area_wide[a[23:21]];
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      if (sz == 2'd3 || (sz != 2'd0 && a[0])) begin
         exp_res.push_back({1'b1, 1'b0, 32'h0});        // R7
      end else begin
         rd_exp = '0;
         for (int k = 0; k < nb; k++) begin
            b[k] = wr ? 8'(wd >> (8 * (nb - 1 - k))) : mem_byte(a + 24'(k));   // R6
            rd_exp = {rd_exp[23:0], mem_byte(a + 24'(k))};
         end
         if (!wide) begin                                 // R3
            for (int k = 0; k < nb; k++)
               exp_cyc.push_back({wr, a + 24'(k), 1'b1, 1'b0, b[k], 8'h00});
         end else if (nb == 1) begin                      // R4
            if (a[0]) exp_cyc.push_back({wr, a, 1'b0, 1'b1, 8'h00, b[0]});
            else      exp_cyc.push_back({wr, a, 1'b1, 1'b0, b[0], 8'h00});
         end else begin                                   // R5
            for (int k = 0; k < nb / 2; k++)
               exp_cyc.push_back({wr, a + 24'(2 * k), 1'b1, 1'b1, b[2 * k], b[2 * k + 1]});
         end
         exp_res.push_back({1'b0, !wr, rd_exp});
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor and responder
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done && err) check(0, "R7 done/err overlap", {done, err}, 2'b00);
         if (done || err) begin
            if (exp_res.size() == 0) begin
               check(0, "R9 unexpected completion", {done, err}, 0);
            end else begin
               logic [33:0] r;
               r = exp_res.pop_front();
               if (r[33]) check(err && !done, "R7 error pulse", {done, err}, 2'b01);
               else begin
                  check(done && !err, "R9 done pulse", {done, err}, 2'b10);
                  if (r[32]) check(rdata == r[31:0], "R9 read data", rdata, r[31:0]);
               end
            end
         end
         ext_ready = ext_valid && ($urandom_range(0, 2) != 0);
         if (ext_valid && ext_ready) begin
            if (exp_cyc.size() == 0) begin
               check(0, "R1 unexpected bus cycle", ext_addr, 0);
            end else begin
               logic [42:0] c;
               c = exp_cyc.pop_front();
               check(ext_write == c[42], "R1 direction", ext_write, c[42]);
               check(ext_addr == c[41:18], "R6 cycle address", ext_addr, c[41:18]);
               check({ext_upper_en, ext_lower_en} == c[17:16], "R3 lane enables",
                     {ext_upper_en, ext_lower_en}, c[17:16]);
               if (c[42]) check(ext_wdata == c[15:0], "R10 write lanes", ext_wdata, c[15:0]);
            end
            if (ext_upper_en && ext_lower_en) ext_rdata = {mem_byte(ext_addr), mem_byte(ext_addr + 24'd1)};
            else if (ext_upper_en)            ext_rdata = {mem_byte(ext_addr), 8'hEE};
            else                              ext_rdata = {8'hEE, mem_byte(ext_addr)};
         end else begin
            ext_rdata = 16'hDEAD;
         end
      end
   end

   task automatic drain();
      int guard = 0;
      while ((exp_res.size() != 0 || !req_ready) && guard < 2000) begin
         @(negedge clk); guard++;
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!ext_valid && !done && !err && req_ready, "R1 reset state",
            {ext_valid, done, err, req_ready}, 4'b0001);
      rst_n = 1'b1;
      @(negedge clk);
      // narrow area 0
      issue(0, 2'd0, 24'h000010, 0);             // R3 byte even
      issue(0, 2'd0, 24'h000013, 0);             // R3 byte odd stays upper
      issue(0, 2'd1, 24'h000020, 0);             // R3 word = 2 cycles
      issue(0, 2'd2, 24'h000040, 0);             // R3 R6 long = 4 cycles
      issue(1, 2'd2, 24'h000080, 32'h11223344);  // R10 narrow long write
      issue(1, 2'd1, 24'h0000A2, 32'h0000BEEF);  // R10 narrow word write
      // wide area 1
      issue(0, 2'd0, 24'h200010, 0);             // R4 even upper
      issue(0, 2'd0, 24'h200011, 0);             // R4 odd lower
      issue(1, 2'd0, 24'h200021, 32'h000000C3);  // R4 R10 odd write
      issue(1, 2'd0, 24'h200022, 32'h0000005A);  // R4 R10 even write
      issue(0, 2'd1, 24'h200030, 0);             // R5 word
      issue(0, 2'd2, 24'h200040, 0);             // R5 R6 long
      issue(1, 2'd2, 24'h7000F0, 32'hCAFEF00D);  // R5 long write in area 3
      // errors
      issue(0, 2'd1, 24'h200031, 0);             // R7 misaligned word
      issue(1, 2'd2, 24'h000043, 32'h1);         // R7 misaligned long
      issue(0, 2'd3, 24'h000044, 0);             // R7 reserved size
      drain();
      check(!ext_valid && exp_cyc.size() == 0, "R7 no cycle after error", exp_cyc.size(), 0);
      // R2: width captured at acceptance
      issue(0, 2'd2, 24'h000100, 0);
      area_wide[0] = 1'b1;
      repeat (3) @(negedge clk);
      area_wide[0] = 1'b0;
      drain();
      area_wide[0] = 1'b1;
      issue(0, 2'd2, 24'h000200, 0);             // R2 area 0 now wide
      drain();
      area_wide[0] = 1'b0;
      // R1: stray request while busy is ignored
      issue(0, 2'd2, 24'h000300, 0);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 24'h000555;
      @(negedge clk);
      req_valid = 1'b0;
      drain();
      repeat (20) @(negedge clk);
      check(!ext_valid && exp_cyc.size() == 0 && exp_res.size() == 0, "R1 busy request ignored",
            {ext_valid, 8'(exp_cyc.size())}, 0);
      check(rdata == {mem_byte(24'h300), mem_byte(24'h301), mem_byte(24'h302), mem_byte(24'h303)},
            "R9 rdata held", rdata,
            {mem_byte(24'h300), mem_byte(24'h301), mem_byte(24'h302), mem_byte(24'h303)});
      finished = 1;
      summary();
   end

endmodule